// File: doc/BRIEF.md
# System-Management Memory Window Decoder

This block holds the base and the size of one system-management memory window. For every physical memory access it decides whether the access is steered to system-management memory or to ordinary main memory. It also masks the incoming system-management interrupt request. The window is set through a byte-wide configuration write port. Three 8-bit indexes carry the base page bits and the size code. The access side is purely combinational by default. A parameter adds one register stage on both outputs for timing.

The size code is a power-of-two encoding that starts at 4 KB. The top code covers the whole 32-bit space. The comparison ignores base bits that fall inside the window, so a base that is not aligned to the window size behaves as if it were rounded down. Two override controls steer hits in opposite directions. One forces hits to system-management memory even outside the mode and blocks the interrupt. The other sends data hits to main memory while in the mode.

Top module: `smm_window_decode`

## Requirements
- R1: After reset the size code is 0 (window off) and the base is 0, so `smm_sel` is 0 for every access, including accesses made in system-management mode.
- R2: A write with `cfg_idx`=CDh loads base address bits 31:24 from `cfg_wdata`. CEh loads bits 23:16. CFh loads bits 15:12 from `cfg_wdata[7:4]` and the size code from `cfg_wdata[3:0]`. A write to any other index leaves the window unchanged.
- R3: Size code 0 disables the window. A code k from 1 to 14 gives a window of 2^(11+k) bytes (1 means 4 KB, 6 means 128 KB, 14 means 32 MB). An address hits when its bits 31:(11+k) equal the same bits of the base.
- R4: Size code Fh makes every 32-bit address hit.
- R5: Base bits below the window size are ignored. For example, base 000B0000h with a 128 KB window decodes as the window at 000A0000h.
- R6: With no override set, a hit in system-management mode (`cpu_in_smm`=1) selects system-management memory. A hit outside that mode selects main memory. A miss always selects main memory.
- R7: When `smm_acc_ovr`=1, every hit selects system-management memory, whatever the mode and whatever `main_acc_ovr` is.
- R8: When `main_acc_ovr`=1 and `smm_acc_ovr`=0, a data hit (`acc_is_data`=1) in system-management mode selects main memory. A code fetch (`acc_is_data`=0) still selects system-management memory.
- R9: `smi_req` equals `smi_in` only when `smi_en`=1 and `smm_acc_ovr`=0. Otherwise it is 0.
- R10: With `REG_OUT`=0 (the default), both outputs follow the access inputs within the same cycle, with no clock edge in between.
- R11: With `REG_OUT`=1, both outputs appear one clock after their inputs and are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| acc_addr | input | 32 | Physical address of the access |
| acc_is_data | input | 1 | 1 for a data access, 0 for a code fetch |
| cpu_in_smm | input | 1 | Processor is in system-management mode |
| smi_in | input | 1 | Raw system-management interrupt request |
| smi_en | input | 1 | Interrupt input enable |
| smm_acc_ovr | input | 1 | Force hits to system-management memory |
| main_acc_ovr | input | 1 | Send data hits in the mode to main memory |
| smm_sel | output | 1 | 1 routes the access to system-management memory |
| smi_req | output | 1 | Masked interrupt request |

## Verification
Corrupted window state shows up directly at the ports. A wrong size code or base bit moves the hit boundary, which appears as a wrong `smm_sel` at the first or last page of the window or just outside it. A disabled window that still hits shows up on any access in the mode. The routing decision has no state of its own. An error in the override priority therefore appears on the same access that exercises it, in the same cycle, or one cycle later with the registered option. Probing both window edges for several size codes and crossing each override with mode and access type exposes these faults at once.

// File: rtl/smm_win_pkg.sv
package smm_win_pkg;

    localparam int ADDR_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int PAGE_W     = ADDR_W - PAGE_SHIFT;
    localparam int CODE_W     = 4;
    localparam int BYTE_W     = 8;

    localparam logic [BYTE_W-1:0] IDX_BASE_HI  = 8'hCD;
    localparam logic [BYTE_W-1:0] IDX_BASE_MID = 8'hCE;
    localparam logic [BYTE_W-1:0] IDX_BASE_LO  = 8'hCF;

    localparam logic [CODE_W-1:0] CODE_OFF = 4'h0;
    localparam logic [CODE_W-1:0] CODE_ALL = 4'hF;

    typedef struct packed {
        logic [PAGE_W-1:0] base;
        logic [CODE_W-1:0] code;
    } win_cfg_t;

    typedef struct packed {
        logic smi_en;
        logic smm_acc;
        logic main_acc;
    } ovr_t;

    typedef enum logic {
        ROUTE_MAIN = 1'b0,
        ROUTE_SMM  = 1'b1
    } route_e;

    // Page bits that take part in the compare for a given size code.
    function automatic logic [PAGE_W-1:0] keep_mask(input logic [CODE_W-1:0] code);
        logic [PAGE_W-1:0] m;
        if (code == CODE_ALL)
            m = '0;
        else if (code == CODE_OFF)
            m = '1;
        else
            m = ~((PAGE_W'(1) << (code - 4'd1)) - PAGE_W'(1));
        return m;
    endfunction

    function automatic logic code_enabled(input logic [CODE_W-1:0] code);
        return code != CODE_OFF;
    endfunction

endpackage

// File: rtl/smm_win_regs.sv
module smm_win_regs
    import smm_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [BYTE_W-1:0] cfg_idx,
    input  logic [BYTE_W-1:0] cfg_wdata,
    output win_cfg_t          cfg
);

    localparam int LO_W = PAGE_W - 2 * BYTE_W;

    logic [BYTE_W-1:0] base_hi_q;
    logic [BYTE_W-1:0] base_mid_q;
    logic [LO_W-1:0]   base_lo_q;
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_hi_q  <= '0;
            base_mid_q <= '0;
            base_lo_q  <= '0;
            code_q     <= CODE_OFF;
        end else if (cfg_we) begin
            case (cfg_idx)
                IDX_BASE_HI:  base_hi_q  <= cfg_wdata;
                IDX_BASE_MID: base_mid_q <= cfg_wdata;
                IDX_BASE_LO: begin
                    base_lo_q <= cfg_wdata[BYTE_W-1 -: LO_W];
                    code_q    <= cfg_wdata[CODE_W-1:0];
                end
                default: ;
            endcase
        end
    end

    assign cfg.base = {base_hi_q, base_mid_q, base_lo_q};
    assign cfg.code = code_q;

    AST_SIZE_LOADS: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_idx == IDX_BASE_LO) |=> cfg.code == $past(cfg_wdata[CODE_W-1:0])) // R2
        else $error("size code not loaded");
    AST_FOREIGN_IDX_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_idx != IDX_BASE_HI && cfg_idx != IDX_BASE_MID && cfg_idx != IDX_BASE_LO)
        |=> $stable(cfg)) // R2
        else $error("foreign index changed window");
    AST_RESET_OFF: assert property (@(posedge clk)
        $past(rst) |-> cfg.code == CODE_OFF) // R1
        else $error("window not off after reset");

endmodule

// File: rtl/smm_win_match.sv
module smm_win_match
    import smm_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PAGE_W-1:0] page,
    input  win_cfg_t          cfg,
    output logic              hit
);

    logic [PAGE_W-1:0] mask;
    logic [PAGE_W-1:0] diff;

    always_comb begin
        mask = keep_mask(cfg.code);
        diff = (page ^ cfg.base) & mask;
        hit  = code_enabled(cfg.code) && (diff == '0);
    end

    AST_OFF_NEVER_HITS: assert property (@(posedge clk) disable iff (rst)
        (cfg.code == CODE_OFF) |-> !hit) // R3
        else $error("disabled window hit");
    AST_FULL_SPACE_HITS: assert property (@(posedge clk) disable iff (rst)
        (cfg.code == CODE_ALL) |-> hit) // R4
        else $error("full-space window missed");
    AST_EXACT_BASE_HITS: assert property (@(posedge clk) disable iff (rst)
        (code_enabled(cfg.code) && page == cfg.base) |-> hit) // R5
        else $error("base page missed");

endmodule

// File: rtl/smm_win_route.sv
module smm_win_route
    import smm_win_pkg::*;
#(
    parameter bit REG_OUT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic is_data,
    input  logic in_smm,
    input  logic smi_in,
    input  ovr_t ovr,
    output logic smm_sel,
    output logic smi_req
);

    route_e route_d;
    logic   smi_d;

    always_comb begin
        route_d = ROUTE_MAIN;
        if (hit) begin
            if (ovr.smm_acc)
                route_d = ROUTE_SMM;
            else if (in_smm && !(ovr.main_acc && is_data))
                route_d = ROUTE_SMM;
        end
        smi_d = smi_in && ovr.smi_en && !ovr.smm_acc;
    end

    generate
        if (REG_OUT) begin : g_reg
            logic sel_q;
            logic smi_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sel_q <= 1'b0;
                    smi_q <= 1'b0;
                end else begin
                    sel_q <= (route_d == ROUTE_SMM);
                    smi_q <= smi_d;
                end
            end
            assign smm_sel = sel_q;
            assign smi_req = smi_q;
        end else begin : g_comb
            assign smm_sel = (route_d == ROUTE_SMM);
            assign smi_req = smi_d;
        end
    endgenerate

    AST_MISS_GOES_MAIN: assert property (@(posedge clk) disable iff (rst)
        !hit |-> route_d == ROUTE_MAIN) // R6
        else $error("miss routed to smm");
    AST_OUTSIDE_MODE_MAIN: assert property (@(posedge clk) disable iff (rst)
        (!in_smm && !ovr.smm_acc) |-> route_d == ROUTE_MAIN) // R6
        else $error("smm memory used outside mode");
    AST_SMM_ACC_WINS: assert property (@(posedge clk) disable iff (rst)
        (hit && ovr.smm_acc) |-> route_d == ROUTE_SMM) // R7
        else $error("smm access override lost");
    AST_FETCH_IGNORES_MAIN: assert property (@(posedge clk) disable iff (rst)
        (hit && in_smm && !is_data) |-> route_d == ROUTE_SMM) // R8
        else $error("code fetch sent to main");
    AST_SMI_GATED: assert property (@(posedge clk) disable iff (rst)
        (!ovr.smi_en || ovr.smm_acc) |-> !smi_d) // R9
        else $error("interrupt leaked");

endmodule

// File: rtl/smm_window_decode.sv
module smm_window_decode
    import smm_win_pkg::*;
#(
    parameter bit REG_OUT = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_idx,
    input  logic [7:0]  cfg_wdata,
    input  logic [31:0] acc_addr,
    input  logic        acc_is_data,
    input  logic        cpu_in_smm,
    input  logic        smi_in,
    input  logic        smi_en,
    input  logic        smm_acc_ovr,
    input  logic        main_acc_ovr,
    output logic        smm_sel,
    output logic        smi_req
);

    win_cfg_t cfg;
    ovr_t     ovr;
    logic     hit;
    logic     unused_offset;

    assign unused_offset = ^acc_addr[PAGE_SHIFT-1:0];
    assign ovr.smi_en   = smi_en;
    assign ovr.smm_acc  = smm_acc_ovr;
    assign ovr.main_acc = main_acc_ovr;

    smm_win_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    smm_win_match u_match (
        .clk  (clk),
        .rst  (rst),
        .page (acc_addr[ADDR_W-1:PAGE_SHIFT]),
        .cfg  (cfg),
        .hit  (hit)
    );

    smm_win_route #(.REG_OUT(REG_OUT)) u_route (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .is_data (acc_is_data),
        .in_smm  (cpu_in_smm),
        .smi_in  (smi_in),
        .ovr     (ovr),
        .smm_sel (smm_sel),
        .smi_req (smi_req)
    );

endmodule

// File: tb/smm_window_decode_bench.sv
`timescale 1ns/1ps
module smm_window_decode_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [7:0]  cfg_idx;
    logic [7:0]  cfg_wdata;
    logic [31:0] acc_addr;
    logic        acc_is_data, cpu_in_smm, smi_in, smi_en, smm_acc_ovr, main_acc_ovr;
    logic        smm_sel, smi_req, q_sel, q_smi;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    smm_window_decode u_smm_window_decode (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .acc_addr(acc_addr), .acc_is_data(acc_is_data), .cpu_in_smm(cpu_in_smm),
        .smi_in(smi_in), .smi_en(smi_en), .smm_acc_ovr(smm_acc_ovr),
        .main_acc_ovr(main_acc_ovr), .smm_sel(smm_sel), .smi_req(smi_req)
    );

    smm_window_decode #(.REG_OUT(1'b1)) u_smm_window_decode_q (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .acc_addr(acc_addr), .acc_is_data(acc_is_data), .cpu_in_smm(cpu_in_smm),
        .smi_in(smi_in), .smi_en(smi_en), .smm_acc_ovr(smm_acc_ovr),
        .main_acc_ovr(main_acc_ovr), .smm_sel(q_sel), .smi_req(q_smi)
    );

    // {addr, is_data, in_smm, smi_in, smi_en, smm_acc, main_acc, exp_sel, exp_smi}
    // window: base 000A0000h, code 6 (128 KB)
    localparam int NVEC = 14;
    localparam logic [39:0] VEC [NVEC] = '{
        {32'h000A0000, 8'b1100_0010},
        {32'h000BFFFF, 8'b1100_0010},
        {32'h000C0000, 8'b1100_0000},
        {32'h0009FFFF, 8'b1100_0000},
        {32'h000A1234, 8'b1000_0000},
        {32'h000A1234, 8'b1000_1010},
        {32'h000A1234, 8'b1100_0100},
        {32'h000A1234, 8'b0100_0110},
        {32'h000A1234, 8'b1100_1110},
        {32'h000A1234, 8'b1011_0001},
        {32'h000A1234, 8'b1010_0000},
        {32'h000A1234, 8'b1011_1010},
        {32'h00100000, 8'b1000_1000},
        {32'h000B0000, 8'b0100_0010}
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] idx, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_window(input logic [31:0] base, input logic [3:0] code);
        cfg_write(8'hCD, base[31:24]);
        cfg_write(8'hCE, base[23:16]);
        cfg_write(8'hCF, {base[15:12], code});
    endtask

    task automatic probe(input logic [31:0] a, input logic d, input logic s);
        acc_addr = a; acc_is_data = d; cpu_in_smm = s;
        smi_in = 1'b0; smi_en = 1'b0; smm_acc_ovr = 1'b0; main_acc_ovr = 1'b0;
        #2;
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
        acc_addr = '0; acc_is_data = 1'b1; cpu_in_smm = 1'b0;
        smi_in = 1'b0; smi_en = 1'b0; smm_acc_ovr = 1'b0; main_acc_ovr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, no window even in the mode
        probe(32'h00000000, 1'b1, 1'b1);
        check("R1 reset sel addr 0", smm_sel, 1'b0);
        check("R1 reset registered sel", q_sel, 1'b0);
        check("R1 reset smi", smi_req, 1'b0);

        set_window(32'h000A0000, 4'h6);
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            acc_addr     = VEC[i][39:8];
            acc_is_data  = VEC[i][7];
            cpu_in_smm   = VEC[i][6];
            smi_in       = VEC[i][5];
            smi_en       = VEC[i][4];
            smm_acc_ovr  = VEC[i][3];
            main_acc_ovr = VEC[i][2];
            #2; // R10: same cycle, no clock edge
            check($sformatf("R3 R6 R7 R8 vec %0d sel", i), smm_sel, VEC[i][1]);
            check($sformatf("R9 vec %0d smi", i), smi_req, VEC[i][0]);
        end

        // R2: foreign index leaves the window in place
        cfg_write(8'hD0, 8'hFF);
        cfg_write(8'hCC, 8'h00);
        probe(32'h000A0000, 1'b1, 1'b1);
        check("R2 foreign index ignored, still hits", smm_sel, 1'b1);
        probe(32'h000C0000, 1'b1, 1'b1);
        check("R2 foreign index ignored, still misses", smm_sel, 1'b0);

        // R5: misaligned base rounded down
        set_window(32'h000B0000, 4'h6);
        probe(32'h000A0000, 1'b1, 1'b1);
        check("R5 misaligned base low edge", smm_sel, 1'b1);
        probe(32'h000C0000, 1'b1, 1'b1);
        check("R5 misaligned base above", smm_sel, 1'b0);

        // R3: smallest window, 4 KB
        set_window(32'h12345000, 4'h1);
        probe(32'h12345FFF, 1'b1, 1'b1);
        check("R3 4KB last byte", smm_sel, 1'b1);
        probe(32'h12346000, 1'b1, 1'b1);
        check("R3 4KB next page", smm_sel, 1'b0);
        probe(32'h12344FFF, 1'b1, 1'b1);
        check("R3 4KB prev page", smm_sel, 1'b0);

        // R3: largest finite window, 32 MB
        set_window(32'h02000000, 4'hE);
        probe(32'h03FFFFFF, 1'b1, 1'b1);
        check("R3 32MB top", smm_sel, 1'b1);
        probe(32'h04000000, 1'b1, 1'b1);
        check("R3 32MB above", smm_sel, 1'b0);

        // R4: whole space
        set_window(32'h55555000, 4'hF);
        probe(32'hFFFFFFFF, 1'b1, 1'b1);
        check("R4 full space top", smm_sel, 1'b1);
        probe(32'h00000000, 1'b0, 1'b1);
        check("R4 full space bottom", smm_sel, 1'b1);

        // R3: code 0 disables
        set_window(32'h55555000, 4'h0);
        probe(32'h55555000, 1'b1, 1'b1);
        check("R3 code 0 off", smm_sel, 1'b0);

        // R11: registered variant lags one clock
        set_window(32'h000A0000, 4'h6);
        @(negedge clk);
        probe(32'h000A0000, 1'b1, 1'b0);
        @(negedge clk);
        cpu_in_smm = 1'b1; smi_in = 1'b1; smi_en = 1'b1;
        #2;
        check("R10 comb sel immediate", smm_sel, 1'b1);
        check("R11 registered sel before edge", q_sel, 1'b0);
        check("R11 registered smi before edge", q_smi, 1'b0);
        @(negedge clk);
        #2;
        check("R11 registered sel after edge", q_sel, 1'b1);
        check("R11 registered smi after edge", q_smi, 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule